// File: doc/BRIEF.md
# Clock Run-In and Start-Bit Detector

This block watches the binary output of a video data slicer during one enabled line of a field. While an externally positioned run-in window is high, it counts rising pulses of the synchronized data bit. At the end of that window it decides whether a valid clock run-in was present: the count must lie in a narrow band. A counter that reaches its overflow limit stops counting and latches an overflow indication until the line is restarted.

After a valid run-in, the block looks for the start bit inside a second window. When the start bit is found, a one-cycle data-sampling strobe is issued aligned to it. When the window closes without a start bit, the strobe is issued after a programmable 5-bit delay counted from the window end. The line then finishes and an interrupt pulse is raised. Software enables a line with a write strobe, which clears the status byte, and reads the status byte after a field-completion pulse has copied the line's results into it.

Top module: `runin_startbit_det`

## Requirements
- R1: The data bit passes through a two-flop synchronizer. A rising edge is counted only while the run-in window input is high and the line is active. Status bits 3:0 show the count at the last snapshot, clamped at 15.
- R2: When the run-in window falls during an active line, the run-in flag (status bit 7) is set if the count then lies between 3 and 7 inclusive and there is no overflow. Otherwise the flag is cleared.
- R3: At the 16th counted pulse the overflow flag (status bit 5) latches and further pulses are ignored until the line restarts. An overflowed line never reports a valid run-in.
- R4: After a valid run-in, the first synchronized rising edge inside the start-bit window sets the start-bit flag (status bit 6). In that same clock edge, sample_stb_o is driven high for one cycle.
- R5: If the start-bit window falls during an active line and no start bit was found, sample_stb_o pulses once. The pulse is high in the cycle after edge E+1+D, where E is the edge at which the window is first seen low and D is dly_i sampled at E.
- R6: A line-enable write clears status_o to 0x00, clears all run-in and start-bit results, cancels a pending delayed strobe and starts a new active line. It takes priority over field_done_i in the same cycle.
- R7: Reset or halt_i sets status_o to 0x10 and clears the active line, the results, the strobe and the interrupt. Status bit 4 is 1 only in this state.
- R8: status_o changes only on reset, halt_i, a line-enable write, or field_done_i. On field_done_i it copies {run-in flag, start flag, overflow, 0, clamped count} from the line results as they stood before that edge.
- R9: slice_irq_o pulses for exactly one cycle after the edge at which the start-bit window is seen to fall during an active line. The line then becomes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Module-stop or low-power condition; holds the block in its initial state |
| data_i | input | 1 | Sliced video data bit, asynchronous |
| runin_win_i | input | 1 | Run-in detection window |
| start_win_i | input | 1 | Start-bit search window |
| line_en_wr_i | input | 1 | Write strobe of 1 to the line-enable bit |
| dly_i | input | 5 | Fallback sampling delay in cycles |
| field_done_i | input | 1 | Field slice-completion pulse; copies results to status |
| status_o | output | 8 | Status byte: [7] run-in, [6] start bit, [5] overflow, [4] initial, [3:0] count |
| sample_stb_o | output | 1 | One-cycle data-sampling strobe |
| slice_irq_o | output | 1 | One-cycle line-finished interrupt |

## Verification
Two functions can fall in the same cycle: a line-enable write and a field-completion snapshot. Both write the status byte. The bench drives both strobes in the same cycle, after a line whose results are non-zero. It then expects 0x00 instead of the snapshot, and the per-cycle reference model also predicts that value. A second coincidence is a fallback strobe still counting down while a new line is enabled. The bench restarts a line inside a long delay and expects no strobe.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

   typedef struct packed {
      logic       runin_ok;
      logic       start_ok;
      logic       ovf;
      logic       initial_st;
      logic [3:0] cnt;
   } status_t;

   localparam status_t STATUS_INIT  = '{runin_ok: 1'b0, start_ok: 1'b0, ovf: 1'b0,
                                        initial_st: 1'b1, cnt: 4'h0};
   localparam status_t STATUS_CLEAR = '{runin_ok: 1'b0, start_ok: 1'b0, ovf: 1'b0,
                                        initial_st: 1'b0, cnt: 4'h0};

endpackage

// File: rtl/rsd_sync_edge.sv
module rsd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);
   localparam int SH_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("rsd_sync_edge: STAGES must be at least 2");
   end

   logic [SH_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SH_W-2:0], d_i};
   end

   // Rising edge seen between the last synchronizer stage and the delay flop
   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rsd_runin.sv
module rsd_runin #(
   parameter int OVF_AT  = 16,
   parameter int LO_OK   = 3,
   parameter int HI_OK   = 7,
   parameter int CNT_W   = $clog2(OVF_AT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             active_i,
   input  logic             win_i,
   input  logic             rise_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o,
   output logic             valid_o
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVF_AT - 1);
   localparam logic [CNT_W-1:0] LO   = CNT_W'(LO_OK);
   localparam logic [CNT_W-1:0] HI   = CNT_W'(HI_OK);

   if (LO_OK > HI_OK || HI_OK >= OVF_AT) begin : g_bad_band
      $error("rsd_runin: band must satisfy LO_OK <= HI_OK < OVF_AT");
   end

   logic win_q;
   logic fall;

   assign fall = win_q & ~win_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= 1'b0;
      else        win_q <= win_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o   <= '0;
         ovf_o   <= 1'b0;
         valid_o <= 1'b0;
      end else if (clr_i) begin
         cnt_o   <= '0;
         ovf_o   <= 1'b0;
         valid_o <= 1'b0;
      end else if (active_i) begin
         if (win_i && rise_i && !ovf_o) begin
            cnt_o <= cnt_o + 1'b1;
            if (cnt_o == LAST) ovf_o <= 1'b1;
         end
         if (fall) valid_o <= (cnt_o >= LO) && (cnt_o <= HI) && !ovf_o;
      end
   end
endmodule

// File: rtl/rsd_start.sv
module rsd_start #(
   parameter int DLY_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             active_i,
   input  logic             armed_i,
   input  logic             win_i,
   input  logic             rise_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             found_o,
   output logic             stb_o,
   output logic             end_o
);
   logic             win_q;
   logic             pend_q;
   logic [DLY_W-1:0] dcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= 1'b0;
      else        win_q <= win_i;
   end

   assign end_o = active_i & win_q & ~win_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found_o <= 1'b0;
         stb_o   <= 1'b0;
         pend_q  <= 1'b0;
         dcnt_q  <= '0;
      end else if (clr_i) begin
         found_o <= 1'b0;
         stb_o   <= 1'b0;
         pend_q  <= 1'b0;
         dcnt_q  <= '0;
      end else begin
         stb_o <= 1'b0;
         if (active_i && armed_i && win_i && rise_i && !found_o) begin
            found_o <= 1'b1;
            stb_o   <= 1'b1;
         end
         if (end_o && !found_o) begin
            pend_q <= 1'b1;
            dcnt_q <= dly_i;
         end
         if (pend_q) begin
            if (dcnt_q == '0) begin
               stb_o  <= 1'b1;
               pend_q <= 1'b0;
            end else begin
               dcnt_q <= dcnt_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/runin_startbit_det.sv
module runin_startbit_det
   import rsd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OVF_AT      = 16,
   parameter int LO_OK       = 3,
   parameter int HI_OK       = 7,
   parameter int DLY_W       = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_i,
   input  logic             data_i,
   input  logic             runin_win_i,
   input  logic             start_win_i,
   input  logic             line_en_wr_i,
   input  logic [DLY_W-1:0] dly_i,
   input  logic             field_done_i,
   output logic [7:0]       status_o,
   output logic             sample_stb_o,
   output logic             slice_irq_o
);
   localparam int CNT_W = $clog2(OVF_AT + 1);

   logic             rise;
   logic             clr;
   logic             active_q;
   logic [CNT_W-1:0] cnt;
   logic             ovf;
   logic             runin_ok;
   logic             start_ok;
   logic             line_end;
   logic [3:0]       cnt_view;
   status_t          status_q;

   assign clr = halt_i | line_en_wr_i;

   rsd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (data_i),
      .rise_o (rise)
   );

   rsd_runin #(.OVF_AT(OVF_AT), .LO_OK(LO_OK), .HI_OK(HI_OK)) u_runin (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .active_i (active_q),
      .win_i    (runin_win_i),
      .rise_i   (rise),
      .cnt_o    (cnt),
      .ovf_o    (ovf),
      .valid_o  (runin_ok)
   );

   rsd_start #(.DLY_W(DLY_W)) u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .active_i (active_q),
      .armed_i  (runin_ok),
      .win_i    (start_win_i),
      .rise_i   (rise),
      .dly_i    (dly_i),
      .found_o  (start_ok),
      .stb_o    (sample_stb_o),
      .end_o    (line_end)
   );

   // Count view clamps to the four status bits
   if (CNT_W > 4) begin : g_clamp
      assign cnt_view = (cnt > CNT_W'(15)) ? 4'hF : cnt[3:0];
   end else begin : g_widen
      assign cnt_view = 4'(cnt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q    <= 1'b0;
         slice_irq_o <= 1'b0;
         status_q    <= STATUS_INIT;
      end else if (halt_i) begin
         active_q    <= 1'b0;
         slice_irq_o <= 1'b0;
         status_q    <= STATUS_INIT;
      end else begin
         slice_irq_o <= line_end;
         if (line_en_wr_i) begin
            active_q <= 1'b1;
            status_q <= STATUS_CLEAR;
         end else begin
            if (line_end) active_q <= 1'b0;
            if (field_done_i)
               status_q <= '{runin_ok: runin_ok, start_ok: start_ok, ovf: ovf,
                             initial_st: 1'b0, cnt: cnt_view};
         end
      end
   end

   assign status_o = status_q;
endmodule

// File: rtl/runin_startbit_chk.sv
module runin_startbit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       halt_i,
   input logic       line_en_wr_i,
   input logic       field_done_i,
   input logic [7:0] status_o,
   input logic       sample_stb_o,
   input logic       slice_irq_o
);
   // R6
   clear_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_en_wr_i && !halt_i) |=> (status_o == 8'h00));

   // R7
   halt_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> (status_o == 8'h10 && !sample_stb_o && !slice_irq_o));

   // R8
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!field_done_i && !line_en_wr_i && !halt_i) |=> $stable(status_o));

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[5] |-> !status_o[7]);

   // R9
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slice_irq_o |=> !slice_irq_o);

   // R5
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb_o |=> !sample_stb_o);
endmodule

bind runin_startbit_det runin_startbit_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .halt_i       (halt_i),
   .line_en_wr_i (line_en_wr_i),
   .field_done_i (field_done_i),
   .status_o     (status_o),
   .sample_stb_o (sample_stb_o),
   .slice_irq_o  (slice_irq_o)
);

// File: tb/tb_runin_startbit_det.sv
module tb_runin_startbit_det;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       halt_i = 1'b0;
   logic       data_i = 1'b0;
   logic       runin_win_i = 1'b0;
   logic       start_win_i = 1'b0;
   logic       line_en_wr_i = 1'b0;
   logic [4:0] dly_i = 5'd0;
   logic       field_done_i = 1'b0;
   logic [7:0] status_o;
   logic       sample_stb_o;
   logic       slice_irq_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int strobes = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   runin_startbit_det dut (.*);

   // Behavioural reference model
   bit   hist[$];
   bit   m_active, m_ovf, m_valid, m_found, m_pend, m_stb, m_irq;
   int   m_cnt, m_dcnt;
   bit   m_rprev, m_sprev;
   logic [7:0] m_status;

   task automatic model_reset();
      hist = {1'b0, 1'b0, 1'b0};
      m_active = 0; m_ovf = 0; m_valid = 0; m_found = 0; m_pend = 0;
      m_stb = 0; m_irq = 0; m_cnt = 0; m_dcnt = 0; m_rprev = 0; m_sprev = 0;
      m_status = 8'h10;
   endtask

   initial model_reset();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         bit rise, rfall, sfall, lend;
         bit a, o, v, f, p, s, q;
         int c, d;
         logic [7:0] st;
         rise  = hist[1] && !hist[2];
         rfall = m_rprev && !runin_win_i;
         sfall = m_sprev && !start_win_i;
         lend  = m_active && sfall;
         a = m_active; o = m_ovf; v = m_valid; f = m_found; p = m_pend;
         c = m_cnt; d = m_dcnt; st = m_status; s = 0; q = 0;
         if (halt_i) begin
            a = 0; o = 0; v = 0; f = 0; p = 0; c = 0; d = 0; st = 8'h10;
         end else begin
            q = lend;
            if (line_en_wr_i) begin
               a = 1; o = 0; v = 0; f = 0; p = 0; c = 0; d = 0; st = 8'h00;
            end else begin
               if (field_done_i)
                  st = {m_valid, m_found, m_ovf, 1'b0, 4'((m_cnt > 15) ? 15 : m_cnt)};
               if (lend) a = 0;
               if (m_active) begin
                  if (runin_win_i && rise && !m_ovf) begin
                     c = m_cnt + 1;
                     if (c >= 16) o = 1;
                  end
                  if (rfall) v = (m_cnt >= 3 && m_cnt <= 7 && !m_ovf);
                  if (m_valid && start_win_i && rise && !m_found) begin
                     f = 1; s = 1;
                  end
                  if (sfall && !m_found) begin
                     p = 1; d = int'(dly_i);
                  end
               end
               if (m_pend) begin
                  if (m_dcnt == 0) begin s = 1; p = 0; end
                  else d = m_dcnt - 1;
               end
            end
         end
         m_active = a; m_ovf = o; m_valid = v; m_found = f; m_pend = p;
         m_cnt = c; m_dcnt = d; m_status = st; m_stb = s; m_irq = q;
         m_rprev = runin_win_i; m_sprev = start_win_i;
         hist.push_front(data_i);
         void'(hist.pop_back());
      end
   end

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (sample_stb_o === 1'b1) strobes++;
      if (rst_n) begin
         check("R1/R2/R3/R4/R8 status", status_o, m_status);
         check("R4/R5 strobe", {7'd0, sample_stb_o}, {7'd0, m_stb});
         check("R9 irq", {7'd0, slice_irq_o}, {7'd0, m_irq});
      end
   end

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_line_en();
      line_en_wr_i = 1'b1; wait_cyc(1); line_en_wr_i = 1'b0;
   endtask

   task automatic pulse_field_done();
      field_done_i = 1'b1; wait_cyc(1); field_done_i = 1'b0; wait_cyc(1);
   endtask

   // One line: run-in pulses, optional start bit, fallback delay
   task automatic run_line(int npulse, bit with_start, logic [4:0] dly);
      pulse_line_en();
      dly_i = dly;
      wait_cyc(2);
      runin_win_i = 1'b1;
      wait_cyc(3);
      for (int i = 0; i < npulse; i++) begin
         data_i = 1'b1; wait_cyc(2);
         data_i = 1'b0; wait_cyc(2);
      end
      wait_cyc(4);
      runin_win_i = 1'b0;
      wait_cyc(3);
      start_win_i = 1'b1;
      wait_cyc(3);
      if (with_start) begin
         data_i = 1'b1; wait_cyc(3); data_i = 1'b0;
      end
      wait_cyc(4);
      start_win_i = 1'b0;
      wait_cyc(40);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      int s0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R7 reset value
      check("R7 reset", status_o, 8'h10);

      // R2 R4: five pulses and a start bit
      s0 = strobes;
      run_line(5, 1'b1, 5'd2);
      pulse_field_done();
      check("R2/R4 five pulses", status_o, 8'hC5);
      check("R4 one strobe", 8'(strobes - s0), 8'd1);

      // R2 R5: two pulses, start bit ignored, fallback strobe
      s0 = strobes;
      run_line(2, 1'b1, 5'd3);
      pulse_field_done();
      check("R2/R5 two pulses", status_o, 8'h02);
      check("R5 fallback strobe", 8'(strobes - s0), 8'd1);

      // R2 band edges
      run_line(7, 1'b0, 5'd0);
      pulse_field_done();
      check("R2 seven pulses", status_o, 8'h87);
      run_line(3, 1'b0, 5'd31);
      pulse_field_done();
      check("R2 three pulses", status_o, 8'h83);
      run_line(8, 1'b1, 5'd1);
      pulse_field_done();
      check("R2 eight pulses", status_o, 8'h08);

      // R3 overflow
      run_line(20, 1'b1, 5'd4);
      pulse_field_done();
      check("R3 overflow", status_o, 8'h2F);

      // R1 pulses outside the window are not counted
      pulse_line_en();
      for (int i = 0; i < 4; i++) begin
         data_i = 1'b1; wait_cyc(2); data_i = 1'b0; wait_cyc(2);
      end
      wait_cyc(4);
      pulse_field_done();
      check("R1 outside window", status_o, 8'h00);

      // R6 enable and field-done in the same cycle
      run_line(4, 1'b1, 5'd0);
      line_en_wr_i = 1'b1; field_done_i = 1'b1;
      wait_cyc(1);
      line_en_wr_i = 1'b0; field_done_i = 1'b0;
      check("R6 enable wins", status_o, 8'h00);

      // R6 restart cancels a pending fallback strobe
      s0 = strobes;
      pulse_line_en();
      dly_i = 5'd31;
      start_win_i = 1'b1; wait_cyc(3); start_win_i = 1'b0;
      wait_cyc(5);
      pulse_line_en();
      wait_cyc(40);
      check("R6 cancel strobe", 8'(strobes - s0), 8'd0);

      // R7 halt
      run_line(5, 1'b1, 5'd0);
      pulse_field_done();
      halt_i = 1'b1; wait_cyc(3);
      check("R7 halt", status_o, 8'h10);
      halt_i = 1'b0; wait_cyc(2);
      check("R8 hold after halt", status_o, 8'h10);

      done = 1'b1;
      finish_run();
   end

   initial begin
      for (int i = 0; i < 100000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end
endmodule